// File: doc/BRIEF.md
# Scalar Hash Sigma Function Unit

This unit computes the six one-operand mixing functions used by two common hash families: the four 32-bit message-schedule and compression sigmas of SHA-256, and the two permutations of SM3. A core's execute stage gives it a 3-bit operation code, one source register and the enable state of the two hash sub-extensions. It returns a destination value and a flag that marks the operation as illegal.

Every function is the XOR of three terms derived from the low 32 bits of the source. A small decoder turns the operation code into three rotate amounts and one flag that makes the third term a logical shift. A single three-term XOR datapath evaluates that description. The 32-bit result is sign-extended to the register width XLEN. A parameter adds one optional output register stage.

Top module: `hash_mix_unit`

## Requirements
- R1: Operation code 0 returns ROTR7(x) ^ ROTR18(x) ^ SHR3(x), where x is source bits [31:0].
- R2: Operation code 1 returns ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R3: Operation code 2 returns ROTR2(x) ^ ROTR13(x) ^ ROTR22(x). Operation code 3 returns ROTR6(x) ^ ROTR11(x) ^ ROTR25(x).
- R4: Operation code 4 returns x ^ ROTL9(x) ^ ROTL17(x). Operation code 5 returns x ^ ROTL15(x) ^ ROTL23(x).
- R5: Source bits above bit 31 have no effect on the result.
- R6: When XLEN is 64, result bits [63:32] all equal result bit 31.
- R7: Codes 0 to 3 raise the illegal flag when the SHA-2 enable is low. Codes 4 and 5 raise the illegal flag when the SM3 enable is low.
- R8: Codes 6 and 7 raise the illegal flag, whatever the enables are.
- R9: Whenever the illegal flag is high, the result is all zeros.
- R10: With REG_OUT=1, result and flag appear on the clock edge after the inputs are applied, and the active-low reset clears both to zero. With REG_OUT=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Function code, 0 to 5 valid |
| src | input | XLEN | Source operand; only bits [31:0] are used |
| en_sha2 | input | 1 | SHA-256 function group enabled |
| en_sm3 | input | 1 | SM3 function group enabled |
| result | output | XLEN | Sign-extended 32-bit function value |
| illegal | output | 1 | Operation not permitted; result forced to zero |

## Verification
All eight codes are swept under all four enable combinations. Each combination is tried with the operand all zeros, all ones, each single set bit and random words.

- **Single-bit operands** expose each rotate or shift amount on its own. They catch a wrong distance, a swapped direction, or a rotate used where a shift belongs.
- **All-ones operands** catch missing zero fill in the two shift terms.
- **All-zeros operands** show that no constant leaks into the XOR.
- **Random operands** carry random upper halves. They show that the upper source bits are ignored and that sign extension follows bit 31 in both polarities.

Both the 64-bit registered build and the 32-bit combinational build are checked.

// File: rtl/hash_mix_pkg.sv
package hash_mix_pkg;

   localparam int WORD_W = 32;
   localparam int AMT_W  = $clog2(WORD_W);

   typedef enum logic [2:0] {
      OP_SHA_SIG0 = 3'd0,
      OP_SHA_SIG1 = 3'd1,
      OP_SHA_SUM0 = 3'd2,
      OP_SHA_SUM1 = 3'd3,
      OP_SM3_P0   = 3'd4,
      OP_SM3_P1   = 3'd5,
      OP_RSVD_6   = 3'd6,
      OP_RSVD_7   = 3'd7
   } hm_op_e;

   // Each function is described as three right-rotate distances; the third
   // term may instead be a logical right shift.
   typedef struct packed {
      logic [AMT_W-1:0] amt_a;
      logic [AMT_W-1:0] amt_b;
      logic [AMT_W-1:0] amt_c;
      logic             c_shift;
      logic             legal;
   } hm_ctl_t;

endpackage

// File: rtl/hash_mix_ctl.sv
module hash_mix_ctl
   import hash_mix_pkg::*;
(
   input  logic [2:0] op_sel,
   input  logic       en_sha2,
   input  logic       en_sm3,
   output hm_ctl_t    ctl
);

   hm_op_e op;
   assign op = hm_op_e'(op_sel);

   always_comb begin
      ctl = '0;
      unique case (op)
         OP_SHA_SIG0: begin
            ctl.amt_a = AMT_W'(7);  ctl.amt_b = AMT_W'(18); ctl.amt_c = AMT_W'(3);
            ctl.c_shift = 1'b1;     ctl.legal = en_sha2;
         end
         OP_SHA_SIG1: begin
            ctl.amt_a = AMT_W'(17); ctl.amt_b = AMT_W'(19); ctl.amt_c = AMT_W'(10);
            ctl.c_shift = 1'b1;     ctl.legal = en_sha2;
         end
         OP_SHA_SUM0: begin
            ctl.amt_a = AMT_W'(2);  ctl.amt_b = AMT_W'(13); ctl.amt_c = AMT_W'(22);
            ctl.legal = en_sha2;
         end
         OP_SHA_SUM1: begin
            ctl.amt_a = AMT_W'(6);  ctl.amt_b = AMT_W'(11); ctl.amt_c = AMT_W'(25);
            ctl.legal = en_sha2;
         end
         // left rotations expressed as right rotations by WORD_W - n
         OP_SM3_P0: begin
            ctl.amt_a = '0;
            ctl.amt_b = AMT_W'(WORD_W - 9);
            ctl.amt_c = AMT_W'(WORD_W - 17);
            ctl.legal = en_sm3;
         end
         OP_SM3_P1: begin
            ctl.amt_a = '0;
            ctl.amt_b = AMT_W'(WORD_W - 15);
            ctl.amt_c = AMT_W'(WORD_W - 23);
            ctl.legal = en_sm3;
         end
         default: ctl = '0;
      endcase
   end

   // R1, R2: only the two schedule sigmas use a shift term
   always_comb begin
      assert_shift_only_sigma_R1: assert (!ctl.c_shift || op_sel[2:1] == 2'b00);
   end

endmodule

// File: rtl/hash_mix_xor3.sv
module hash_mix_xor3
   import hash_mix_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  hm_ctl_t           ctl,
   output logic [WORD_W-1:0] mixed
);

   logic [2*WORD_W-1:0] dbl;
   logic [WORD_W-1:0]   term_a, term_b, term_c;
   logic [2*WORD_W-1:0] rot_a, rot_b, rot_c;

   assign dbl   = {word, word};
   assign rot_a = dbl >> ctl.amt_a;
   assign rot_b = dbl >> ctl.amt_b;
   assign rot_c = dbl >> ctl.amt_c;

   assign term_a = rot_a[WORD_W-1:0];
   assign term_b = rot_b[WORD_W-1:0];
   assign term_c = ctl.c_shift ? (word >> ctl.amt_c) : rot_c[WORD_W-1:0];

   assign mixed = ctl.legal ? (term_a ^ term_b ^ term_c) : '0;

endmodule

// File: rtl/hash_mix_unit.sv
module hash_mix_unit
   import hash_mix_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int REG_OUT = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op_sel,
   input  logic [XLEN-1:0] src,
   input  logic            en_sha2,
   input  logic            en_sm3,
   output logic [XLEN-1:0] result,
   output logic            illegal
);

   localparam int EXT_W = XLEN - WORD_W;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("hash_mix_unit: XLEN must be 32 or 64");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("hash_mix_unit: REG_OUT must be 0 or 1");
      end
   endgenerate

   hm_ctl_t           ctl;
   logic [WORD_W-1:0] mix_w;
   logic [WORD_W-1:0] word_o;
   logic              ill_o;

   hash_mix_ctl u_ctl (
      .op_sel  (op_sel),
      .en_sha2 (en_sha2),
      .en_sm3  (en_sm3),
      .ctl     (ctl)
   );

   hash_mix_xor3 u_dp (
      .word  (src[WORD_W-1:0]),
      .ctl   (ctl),
      .mixed (mix_w)
   );

   generate
      if (REG_OUT == 1) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_o <= '0;
               ill_o  <= 1'b0;
            end else begin
               word_o <= mix_w;
               ill_o  <= !ctl.legal;
            end
         end
      end else begin : g_comb
         assign word_o = mix_w;
         assign ill_o  = !ctl.legal;
      end

      if (EXT_W > 0) begin : g_ext
         logic unused_hi;
         assign unused_hi = ^src[XLEN-1:WORD_W];
         assign result    = {{EXT_W{word_o[WORD_W-1]}}, word_o};

         assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
            result[XLEN-1:WORD_W] == {EXT_W{result[WORD_W-1]}});
      end else begin : g_noext
         assign result = word_o;
      end
   endgenerate

   assign illegal = ill_o;

   assert_zero_when_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == '0));

   generate
      if (REG_OUT == 1) begin : g_chk_reg
         assert_reserved_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel[2:1] == 2'b11) |=> illegal);
         assert_group_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((!en_sha2 && !op_sel[2]) || (!en_sm3 && op_sel[2:1] == 2'b10)) |=> illegal);
      end else begin : g_chk_comb
         assert_reserved_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel[2:1] == 2'b11) |-> illegal);
         assert_group_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((!en_sha2 && !op_sel[2]) || (!en_sm3 && op_sel[2:1] == 2'b10)) |-> illegal);
      end
   endgenerate

endmodule

// File: tb/hash_mix_unit_test.sv
`timescale 1ns/1ps
module hash_mix_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [63:0] src = '0;
   logic        en_sha2 = 1'b0;
   logic        en_sm3 = 1'b0;
   logic [63:0] res64;
   logic        ill64;
   logic [31:0] res32;
   logic        ill32;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   hash_mix_unit #(.XLEN(64), .REG_OUT(1)) uut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src(src),
      .en_sha2(en_sha2), .en_sm3(en_sm3), .result(res64), .illegal(ill64));

   hash_mix_unit #(.XLEN(32), .REG_OUT(0)) uut_comb (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src(src[31:0]),
      .en_sha2(en_sha2), .en_sm3(en_sm3), .result(res32), .illegal(ill32));

   function automatic logic [31:0] ror(input logic [31:0] x, input int n);
      return (n == 0) ? x : ((x >> n) | (x << (32 - n)));
   endfunction

   function automatic logic [31:0] rol(input logic [31:0] x, input int n);
      return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
   endfunction

   function automatic logic [31:0] model(input int op, input logic [31:0] x);
      case (op)
         0: return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
         1: return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
         2: return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
         3: return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
         4: return x ^ rol(x, 9) ^ rol(x, 17);
         5: return x ^ rol(x, 15) ^ rol(x, 23);
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit is_legal(input int op, input bit e2, input bit e3);
      if (op < 4) return e2;
      if (op < 6) return e3;
      return 1'b0;
   endfunction

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         4, 5: return "R4";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: op=%0d src=%h actual=%h expected=%h", tag, op_sel, src, act, exp);
      end
   endtask

   task automatic apply(input int op, input logic [63:0] x, input bit e2, input bit e3);
      logic [31:0] w;
      logic [63:0] e64;
      bit          lg;
      lg  = is_legal(op, e2, e3);
      w   = lg ? model(op, x[31:0]) : 32'h0;
      e64 = {{32{w[31]}}, w};
      @(negedge clk);
      op_sel  = op[2:0];
      src     = x;
      en_sha2 = e2;
      en_sm3  = e3;
      #1;
      // R10: combinational build follows inputs
      chk(lg ? tag_of(op) : (op >= 6 ? "R8" : "R7"), {63'd0, ill32}, {63'd0, !lg});
      chk(lg ? tag_of(op) : "R9", {32'd0, res32}, {32'd0, w});
      @(negedge clk);
      // R10: registered build shows the value one edge later
      chk(lg ? "R10" : (op >= 6 ? "R8" : "R7"), {63'd0, ill64}, {63'd0, !lg});
      chk(lg ? "R5" : "R9", {32'd0, res64[31:0]}, {32'd0, w});
      chk("R6", {32'd0, res64[63:32]}, {32'd0, e64[63:32]});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      op_sel  = 3'd0;
      src     = 64'hFFFF_FFFF_FFFF_FFFF;
      en_sha2 = 1'b1;
      en_sm3  = 1'b1;
      repeat (3) @(negedge clk);
      // R10: outputs held at zero during reset despite legal input
      chk("R10", res64, 64'h0);
      chk("R10", {63'd0, ill64}, 64'h0);
      rst_n = 1'b1;

      for (int e = 0; e < 4; e++) begin
         for (int op = 0; op < 8; op++) begin
            apply(op, 64'h0, e[0], e[1]);
            apply(op, 64'hFFFF_FFFF_FFFF_FFFF, e[0], e[1]);
            for (int b = 0; b < 32; b++) begin
               apply(op, (64'h1 << b) | (64'hA5A5_0000_0000_0000 >> (b % 2)), e[0], e[1]);
            end
            for (int r = 0; r < 24; r++) begin
               apply(op, {$urandom, $urandom}, e[0], e[1]);
            end
         end
      end

      // R5: same low word, different upper halves, identical result
      apply(2, 64'h0000_0000_8123_4567, 1'b1, 1'b0);
      apply(2, 64'hDEAD_BEEF_8123_4567, 1'b1, 1'b0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule